// File: doc/BRIEF.md
# Strobe-Driven FIFO with Read Replay

This block is a single-device first-in first-out buffer whose writes and reads are requested by two independent active-low strobes, not by enables tied to a clock. Each strobe, along with the replay request, passes through a short synchronizer in the system clock domain. A falling edge on a synchronized strobe starts a transfer. The block stores words in an internal memory that can be inferred as block RAM. It reports occupancy on three active-low flags: empty, full and more-than-half-full. A read delivers its word on a registered data output together with a valid bit, and this output stands in for a tri-state bus.

A low pulse on the replay input moves the read pointer back to memory location zero and leaves the write pointer where it is. Everything written since reset can then be read out again, provided no more than the memory depth was written. Replay works only when the mode input is held low, which selects single-device operation. When the mode input is high, replay requests are dropped. All three flags are recomputed from the two pointers after a replay.

Top module: `strobe_fifo`

## Requirements
- R1: While `rst` is high at a clock edge, both pointers return to zero and, from the next edge on, `empty_n` is 0, `full_n` is 1, `half_n` is 1 and `dout_vld` is 0.
- R2: A falling edge of `wr_n` starts a write. It acts on the clock edge SYNC_STAGES+1 cycles after the change is sampled and stores `din` at the next location in sequence, whether or not a read is in progress.
- R3: `full_n` is 0 exactly while DEPTH words are held. A write falling edge in that state changes neither the write pointer nor the stored data. `full_n` returns to 1 one cycle after an accepted read.
- R4: A falling edge of `rd_n` with at least one word held registers the oldest unread word on `dout` and sets `dout_vld` to 1 in the same cycle. Words come out in the order they were written.
- R5: `dout_vld` falls to 0 on the clock edge where the synchronized rising edge of `rd_n` is seen.
- R6: `empty_n` is 0 exactly while no word is held. The last read still completes. A read falling edge while empty moves nothing and leaves `dout_vld` at 0. `empty_n` returns to 1 one cycle after an accepted write.
- R7: A falling edge of `rtx_n` with `solo_n` low and both synchronized strobes high sets the read pointer to location zero and keeps the write pointer. The words written since reset are then read again in their original order.
- R8: After an accepted replay, `empty_n`, `full_n` and `half_n` reflect the occupancy given by the write pointer minus zero.
- R9: `half_n` goes to 0 on an accepted write that leaves more than DEPTH/2 words. It goes back to 1 on a synchronized rising edge of `rd_n` that leaves DEPTH/2 words or fewer.
- R10: With `solo_n` high, a falling edge of `rtx_n` has no effect on pointers or flags.
- R11: A falling edge of `rtx_n` while either synchronized strobe is low has no effect.
- R12: A read and a write falling edge seen on the same clock edge, while the buffer is neither empty nor full, both complete and the occupancy is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| solo_n | input | 1 | Low selects single-device mode, which enables replay |
| rtx_n | input | 1 | Active-low replay request |
| wr_n | input | 1 | Active-low write strobe |
| din | input | WIDTH | Write data, held stable while `wr_n` is low |
| rd_n | input | 1 | Active-low read strobe |
| dout | output | WIDTH | Registered read data |
| dout_vld | output | 1 | High while the last read word on `dout` is valid |
| empty_n | output | 1 | Low when no word is held |
| half_n | output | 1 | Low when more than DEPTH/2 words are held |
| full_n | output | 1 | Low when DEPTH words are held |

## Verification
The bench builds the block with DEPTH 16, WIDTH 9 and SYNC_STAGES 2. With this small depth, the full state, the half-full threshold at 8 words and replay of a full write history are reached in a few hundred strobes. A reference model built on a queue and a read index predicts the flags, the valid bit and the read data on every clock. Directed sequences target the blocked write at full and the blocked read at empty. They also cover replay in both modes, replay while a strobe is held low, and simultaneous strobes.

// File: rtl/strobe_fifo_pkg.sv
package strobe_fifo_pkg;

  // Synchronized view of one active-low strobe
  typedef struct packed {
    logic lvl;   // synchronized level
    logic fall;  // high for one cycle after a 1->0 change
    logic rise;  // high for one cycle after a 0->1 change
  } strobe_evt_t;

  function automatic bit is_pow2(input int unsigned v);
    return (v != 0) && ((v & (v - 1)) == 0);
  endfunction

endpackage

// File: rtl/strobe_edge.sv
module strobe_edge
  import strobe_fifo_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        pin_n,
  output strobe_evt_t evt
);

  logic [STAGES-1:0] sh;
  logic              last;

  generate
    if (STAGES > 1) begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sh <= '1;
        else     sh <= {sh[STAGES-2:0], pin_n};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst) sh <= '1;
        else     sh <= pin_n;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last <= 1'b1;
    else     last <= sh[STAGES-1];
  end

  always_comb begin
    evt.lvl  = sh[STAGES-1];
    evt.fall = last & ~sh[STAGES-1];
    evt.rise = ~last & sh[STAGES-1];
  end

endmodule

// File: rtl/fifo_mem.sv
module fifo_mem #(
  parameter int DEPTH = 1024,
  parameter int WIDTH = 9,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= ram[raddr];
  end

endmodule

// File: rtl/fifo_ptr_ctrl.sv
module fifo_ptr_ctrl
  import strobe_fifo_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          solo_n,
  input  strobe_evt_t   wr_evt,
  input  strobe_evt_t   rd_evt,
  input  strobe_evt_t   rtx_evt,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic          mem_re,
  output logic [AW-1:0] mem_raddr,
  output logic          empty_n,
  output logic          full_n,
  output logic          half_n,
  output logic          dout_vld
);

  localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);
  localparam logic [PW-1:0] HALF_CNT = PW'(DEPTH / 2);

  logic [PW-1:0] wp, rp, wp_nxt, rp_nxt, cnt, cnt_nxt;
  logic          rtx_acc, wr_acc, rd_acc;

  logic unused_evt;
  assign unused_evt = wr_evt.rise | rtx_evt.rise | rtx_evt.lvl;

  always_comb begin
    cnt     = wp - rp;
    rtx_acc = rtx_evt.fall & ~solo_n & wr_evt.lvl & rd_evt.lvl;
    wr_acc  = ~rtx_acc & wr_evt.fall & (cnt != FULL_CNT);
    rd_acc  = ~rtx_acc & rd_evt.fall & (cnt != '0);
    wp_nxt  = wp + PW'(wr_acc);
    rp_nxt  = rtx_acc ? '0 : rp + PW'(rd_acc);
    cnt_nxt = wp_nxt - rp_nxt;
  end

  assign mem_we    = wr_acc;
  assign mem_waddr = wp[AW-1:0];
  assign mem_re    = rd_acc;
  assign mem_raddr = rp[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      wp      <= '0;
      rp      <= '0;
      empty_n <= 1'b0;
      full_n  <= 1'b1;
      half_n  <= 1'b1;
      dout_vld <= 1'b0;
    end else begin
      wp      <= wp_nxt;
      rp      <= rp_nxt;
      empty_n <= (cnt_nxt != '0);
      full_n  <= (cnt_nxt != FULL_CNT);
      if (rtx_acc)
        half_n <= ~(cnt_nxt > HALF_CNT);
      else if (wr_acc && (cnt_nxt > HALF_CNT))
        half_n <= 1'b0;
      else if (rd_evt.rise && (cnt_nxt <= HALF_CNT))
        half_n <= 1'b1;
      if (rd_acc)           dout_vld <= 1'b1;
      else if (rd_evt.rise) dout_vld <= 1'b0;
    end
  end

  // R3: a write edge at full leaves the write pointer in place
  p_no_wr_at_full_r3: assert property (@(posedge clk) disable iff (rst)
    (cnt == FULL_CNT) && wr_evt.fall |=> $stable(wp));

  // R6: a read edge while empty leaves the read pointer in place
  p_no_rd_at_empty_r6: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0) && rd_evt.fall && !rtx_acc |=> $stable(rp));

  // R7: replay rewinds the reader only
  p_rtx_rewind_r7: assert property (@(posedge clk) disable iff (rst)
    rtx_acc |=> $stable(wp) && (rp == '0));

  // R5: valid drops after the read strobe rises
  p_vld_drop_r5: assert property (@(posedge clk) disable iff (rst)
    rd_evt.rise |=> !dout_vld);

  // R12: simultaneous accepted read and write keep occupancy
  p_sim_rw_r12: assert property (@(posedge clk) disable iff (rst)
    wr_acc && rd_acc |=> (wp - rp) == $past(wp - rp));

  // R10: replay requests are dropped in expansion mode
  p_rtx_off_r10: assert property (@(posedge clk) disable iff (rst)
    rtx_evt.fall && solo_n && !rd_evt.fall |=> $stable(rp));

endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo
  import strobe_fifo_pkg::*;
#(
  parameter int DEPTH       = 1024,
  parameter int WIDTH       = 9,
  parameter int SYNC_STAGES = 2,
  localparam int AW         = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             solo_n,
  input  logic             rtx_n,
  input  logic             wr_n,
  input  logic [WIDTH-1:0] din,
  input  logic             rd_n,
  output logic [WIDTH-1:0] dout,
  output logic             dout_vld,
  output logic             empty_n,
  output logic             half_n,
  output logic             full_n
);

  generate
    if (!is_pow2(DEPTH) || DEPTH < 2) begin : g_bad_depth
      $error("strobe_fifo: DEPTH must be a power of two of at least 2");
    end
  endgenerate

  strobe_evt_t   wr_evt, rd_evt, rtx_evt;
  logic          mem_we, mem_re;
  logic [AW-1:0] mem_waddr, mem_raddr;

  strobe_edge #(.STAGES(SYNC_STAGES)) u_wr_sync (
    .clk(clk), .rst(rst), .pin_n(wr_n), .evt(wr_evt)
  );
  strobe_edge #(.STAGES(SYNC_STAGES)) u_rd_sync (
    .clk(clk), .rst(rst), .pin_n(rd_n), .evt(rd_evt)
  );
  strobe_edge #(.STAGES(SYNC_STAGES)) u_rtx_sync (
    .clk(clk), .rst(rst), .pin_n(rtx_n), .evt(rtx_evt)
  );

  fifo_ptr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .solo_n    (solo_n),
    .wr_evt    (wr_evt),
    .rd_evt    (rd_evt),
    .rtx_evt   (rtx_evt),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .mem_re    (mem_re),
    .mem_raddr (mem_raddr),
    .empty_n   (empty_n),
    .full_n    (full_n),
    .half_n    (half_n),
    .dout_vld  (dout_vld)
  );

  fifo_mem #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (din),
    .re    (mem_re),
    .raddr (mem_raddr),
    .rdata (dout)
  );

  // R6: the buffer is never reported both empty and full
  p_flags_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(!empty_n && !full_n));

  // R9: more than half implies not empty
  p_half_implies_data_r9: assert property (@(posedge clk) disable iff (rst)
    !half_n |-> empty_n);

endmodule

// File: tb/sim_strobe_fifo.sv
module sim_strobe_fifo;

  localparam int D = 16;
  localparam int W = 9;
  localparam int S = 2;
  localparam int H = D / 2;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         solo_n = 1'b0;
  logic         rtx_n = 1'b1;
  logic         wr_n = 1'b1;
  logic         rd_n = 1'b1;
  logic [W-1:0] din = '0;
  logic [W-1:0] dout;
  logic         dout_vld, empty_n, half_n, full_n;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  strobe_fifo #(.DEPTH(D), .WIDTH(W), .SYNC_STAGES(S)) u0 (
    .clk(clk), .rst(rst), .solo_n(solo_n), .rtx_n(rtx_n),
    .wr_n(wr_n), .din(din), .rd_n(rd_n), .dout(dout),
    .dout_vld(dout_vld), .empty_n(empty_n), .half_n(half_n), .full_n(full_n)
  );

  // ---------------- reference model ----------------
  int       q[$];
  int       ri = 0;
  bit       m_vld = 0;
  bit       m_half = 1;
  int       m_dout = 0;
  bit       hw[0:S], hr[0:S], ht[0:S];

  always @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k <= S; k++) begin hw[k] = 1; hr[k] = 1; ht[k] = 1; end
      q.delete(); ri = 0; m_vld = 0; m_half = 1;
    end else begin
      bit wf, rf, rr, tf, rtx_ok, wacc, racc;
      int c, nc;
      wf = hw[S] && !hw[S-1];
      rf = hr[S] && !hr[S-1];
      rr = !hr[S] && hr[S-1];
      tf = ht[S] && !ht[S-1];
      c = q.size() - ri;
      rtx_ok = tf && !solo_n && hw[S-1] && hr[S-1];
      wacc = 0; racc = 0;
      if (rtx_ok) ri = 0;
      else begin
        wacc = wf && (c < D);
        racc = rf && (c > 0);
        if (racc) begin m_dout = q[ri]; ri++; m_vld = 1; end
        if (wacc) q.push_back(int'(din));
      end
      if (rr) m_vld = 0;
      nc = q.size() - ri;
      if (rtx_ok) m_half = !(nc > H);
      else if (wacc && nc > H) m_half = 0;
      else if (rr && nc <= H) m_half = 1;
      for (int k = S; k > 0; k--) begin hw[k] = hw[k-1]; hr[k] = hr[k-1]; ht[k] = ht[k-1]; end
      hw[0] = wr_n; hr[0] = rd_n; ht[0] = rtx_n;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  bit run_cmp = 0;
  always @(negedge clk) begin
    if (run_cmp && !rst) begin
      int n;
      n = q.size() - ri;
      chk("R6 empty_n", int'(empty_n), int'(n != 0));
      chk("R3 full_n", int'(full_n), int'(n != D));
      chk("R9 half_n", int'(half_n), int'(m_half));
      chk("R5 dout_vld", int'(dout_vld), int'(m_vld));
      if (m_vld) chk("R4 dout", int'(dout), m_dout);
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_wr(input int v);
    din = W'(v); wr_n = 1'b0; idle(4);
    wr_n = 1'b1; idle(4);
  endtask

  task automatic do_rd();
    rd_n = 1'b0; idle(4);
    rd_n = 1'b1; idle(4);
  endtask

  task automatic do_rtx();
    rtx_n = 1'b0; idle(4);
    rtx_n = 1'b1; idle(4);
  endtask

  task automatic do_reset();
    rst = 1'b1; idle(3); rst = 1'b0; idle(2);
  endtask

  initial begin
    idle(3); rst = 1'b0; idle(1);
    // R1: reset state
    chk("R1 empty_n", int'(empty_n), 0);
    chk("R1 full_n", int'(full_n), 1);
    chk("R1 half_n", int'(half_n), 1);
    chk("R1 dout_vld", int'(dout_vld), 0);
    run_cmp = 1;

    // R2 / R4: writes then reads in order
    for (int i = 0; i < 5; i++) do_wr(9'h100 + i * 3);
    chk("R2 empty_n after writes", int'(empty_n), 1);
    do_rd();
    rd_n = 1'b0; idle(4);
    chk("R4 second word", int'(dout), 9'h103);
    rd_n = 1'b1; idle(4);

    // R3 / R9: fill to full, extra write ignored
    for (int i = 0; i < 13; i++) do_wr(9'h0AA ^ i);
    chk("R3 full_n at full", int'(full_n), 0);
    chk("R9 half_n at full", int'(half_n), 0);
    do_wr(9'h1FF);
    chk("R3 still full", int'(full_n), 0);
    // R6: drain and attempt read when empty
    for (int i = 0; i < 16; i++) do_rd();
    chk("R6 empty after drain", int'(empty_n), 0);
    chk("R9 half_n after drain", int'(half_n), 1);
    do_rd();
    chk("R6 read when empty no valid", int'(dout_vld), 0);

    // R7 / R8: replay after reset
    do_reset();
    for (int i = 0; i < 10; i++) do_wr(9'h040 + i);
    for (int i = 0; i < 10; i++) do_rd();
    chk("R8 empty before replay", int'(empty_n), 0);
    do_rtx();
    chk("R8 empty_n after replay", int'(empty_n), 1);
    chk("R8 half_n after replay", int'(half_n), 0);
    rd_n = 1'b0; idle(4);
    chk("R7 replay first word", int'(dout), 9'h040);
    rd_n = 1'b1; idle(4);
    for (int i = 0; i < 9; i++) do_rd();
    chk("R7 drained again", int'(empty_n), 0);

    // R10: expansion mode drops replay
    solo_n = 1'b1; idle(2);
    do_rtx();
    chk("R10 replay ignored", int'(empty_n), 0);
    solo_n = 1'b0; idle(2);

    // R11: replay while read strobe low is dropped
    rd_n = 1'b0; idle(4);
    do_rtx();
    rd_n = 1'b1; idle(4);
    chk("R11 replay ignored", int'(empty_n), 0);

    // R12: simultaneous read and write
    do_reset();
    for (int i = 0; i < 3; i++) do_wr(9'h011 + i);
    din = 9'h0EE; wr_n = 1'b0; rd_n = 1'b0; idle(4);
    chk("R12 read word", int'(dout), 9'h011);
    wr_n = 1'b1; rd_n = 1'b1; idle(4);
    for (int i = 0; i < 3; i++) do_rd();
    chk("R12 occupancy kept", int'(empty_n), 0);

    idle(4);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule